// File: doc/BRIEF.md
# CCD Horizontal Readout Clock Sequencer

This block drives the horizontal shift register of a frame-transfer CCD at logic level. It runs from a master clock that is six times the pixel rate. Each pixel period is split into six sub-slots. From those sub-slots the block builds three overlapping register phases, a reset-gate pulse and a summing-gate window for each register half. It also raises a transport flag that tells the clock drivers when the register is moving. With every transported pixel it emits a one-hot region tag (dummy, black, timing or active), so capture logic downstream knows which samples hold image data.

A line starts on a single-cycle strobe. The strobe also samples a mode input. In single-output mode both register halves shift toward the left output, and the right-hand gates stay low. In split mode the right half shifts the other way, toward its own output, and both halves read out at the same time. Each half then carries only half of the active pixels. After the transport window the register is parked in a fixed idle state until the line period ends. After that the next strobe is accepted.

Top module: `hseq_ccd_sequencer`

## Requirements
- R1: During reset and whenever no pixel is being transported, `xfer` is 0. Both phase buses equal 3'b001 (bit 0 is phase 1, so only phase 1 is high). All four gate outputs are 0 and all four region flags are 0.
- R2: A `line_start` that is sampled high at a clock edge while the block is idle starts a line. The outputs for sub-slot 0 of pixel 0 appear after the next clock edge.
- R3: During transport, sub-slot s (0 to 5) of a pixel sets the left phases as follows: phase 1 (bit 0) is high for s in {0,1,2}, phase 2 (bit 1) for s in {2,3,4}, and phase 3 (bit 2) for s in {4,5,0}.
- R4: During transport `rg_l` is high only in sub-slot 0 of each pixel, and `sg_l` is high in sub-slots 3, 4 and 5.
- R5: In single-output mode `ph_r` equals `ph_l`, and `sg_r` and `rg_r` stay 0.
- R6: In split mode the right phase order is reversed: `ph_r[0]` follows `ph_l[2]`, `ph_r[1]` follows `ph_l[1]` and `ph_r[2]` follows `ph_l[0]`. `sg_r` and `rg_r` equal `sg_l` and `rg_l`.
- R7: A line lasts 1184 pixel periods (7104 clocks). `xfer` is high for the first 1079 pixels in single-output mode and for the first 543 pixels in split mode. The register is idle for the rest of the line.
- R8: In single-output mode the transported pixels are tagged in this order: 7 dummy, 20 black, 4 timing, 1024 active, 4 timing, 20 black. Exactly one flag is high, and it is constant over the six sub-slots of a pixel.
- R9: In split mode the transported pixels are tagged 7 dummy, 20 black, 4 timing, 512 active.
- R10: The mode is taken from `split_mode` at the accepting strobe. Changes of `split_mode` later in the line have no effect on that line.
- R11: `line_start` pulses during a line, including at its last edge, are ignored. A strobe at the first edge after the line ends starts the next line at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, six per pixel |
| rst | input | 1 | Synchronous active-high reset |
| line_start | input | 1 | Line-start strobe |
| split_mode | input | 1 | 1 selects split left/right readout |
| xfer | output | 1 | Start/stop control, high while the register transports |
| ph_l | output | 3 | Left half register phases, bit 0 is phase 1 |
| ph_r | output | 3 | Right half register phases |
| sg_l | output | 1 | Left summing gate |
| sg_r | output | 1 | Right summing gate |
| rg_l | output | 1 | Left reset gate |
| rg_r | output | 1 | Right reset gate |
| rgn_dummy | output | 1 | Current pixel is a dummy cell |
| rgn_black | output | 1 | Current pixel is black reference |
| rgn_timing | output | 1 | Current pixel is a timing column |
| rgn_active | output | 1 | Current pixel is an active sample |

## Verification
The assertions check on every cycle that the sub-slot stays in range, that one or two phases are high during transport, and that a reset-gate pulse never falls outside transport. They also check that the region tag is one-hot while transporting, that the latched mode holds for a whole line, and that a line only begins after a strobe. Only the bench scenarios can show that the region sequence and the transport lengths match the sensor layout in each mode. The same holds for the right half's phases being reversed in split mode, mid-line strobes and mode changes being ignored, and a strobe held high restarting the line exactly one edge after the previous line ends.

// File: rtl/hseq_pkg.sv
package hseq_pkg;
  // sub-slots per pixel period (master clock is six times the pixel rate)
  localparam int SLOTS = 6;
  localparam int SLOT_W = 3;

  typedef enum logic [2:0] {
    REG_NONE,
    REG_DUMMY,
    REG_BLACK,
    REG_TIMING,
    REG_ACTIVE
  } region_e;
endpackage

// File: rtl/hseq_slot_timer.sv
module hseq_slot_timer
  import hseq_pkg::*;
#(
  parameter int LINE_PIX = 1184,
  localparam int PW = $clog2(LINE_PIX)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line_start,
  input  logic              split_req,
  output logic              busy,
  output logic [SLOT_W-1:0] slot,
  output logic [PW-1:0]     pix,
  output logic              split_q
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);
  localparam logic [PW-1:0]     LAST_PIX  = PW'(LINE_PIX - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      slot    <= '0;
      pix     <= '0;
      split_q <= 1'b0;
    end else if (!busy) begin
      if (line_start) begin
        busy    <= 1'b1;
        slot    <= '0;
        pix     <= '0;
        split_q <= split_req;
      end
    end else if (slot == LAST_SLOT) begin
      slot <= '0;
      if (pix == LAST_PIX) begin
        busy <= 1'b0;
        pix  <= '0;
      end else begin
        pix <= pix + 1'b1;
      end
    end else begin
      slot <= slot + 1'b1;
    end
  end

  assert_slot_range_R3: assert property (@(posedge clk) disable iff (rst)
    busy |-> (slot <= LAST_SLOT && pix <= LAST_PIX));
  assert_start_cause_R11: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(line_start));
  assert_mode_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(split_q));
endmodule

// File: rtl/hseq_phase_gen.sv
module hseq_phase_gen
  import hseq_pkg::*;
#(
  parameter int NPH = 3,
  localparam int STEP = SLOTS / NPH,
  localparam int HIGH = SLOTS / 2
) (
  input  logic [SLOT_W-1:0] slot,
  output logic [NPH-1:0]    ph
);
  // phase k is high for HIGH sub-slots starting at STEP*k, wrapping
  always_comb begin
    for (int k = 0; k < NPH; k++) begin
      int d;
      d = (int'(slot) + SLOTS - ((STEP * k) % SLOTS)) % SLOTS;
      ph[k] = (d < HIGH);
    end
  end
endmodule

// File: rtl/hseq_region_tag.sv
module hseq_region_tag
  import hseq_pkg::*;
#(
  parameter int N_DUMMY  = 7,
  parameter int N_BLACK  = 20,
  parameter int N_TIMING = 4,
  parameter int N_ACTIVE = 1024,
  parameter int PW       = 11
) (
  input  logic [PW-1:0] pix,
  input  logic          split,
  output region_e       region,
  output logic          in_xfer
);
  localparam int E_DUM  = N_DUMMY;
  localparam int E_BLK  = E_DUM + N_BLACK;
  localparam int E_TIM  = E_BLK + N_TIMING;
  localparam int E_ACTF = E_TIM + N_ACTIVE;
  localparam int E_ACTH = E_TIM + N_ACTIVE / 2;
  localparam int E_TIM2 = E_ACTF + N_TIMING;
  localparam int E_BLK2 = E_TIM2 + N_BLACK;

  always_comb begin
    in_xfer = split ? (pix < PW'(E_ACTH)) : (pix < PW'(E_BLK2));
    if (!in_xfer)                region = REG_NONE;
    else if (pix < PW'(E_DUM))   region = REG_DUMMY;
    else if (pix < PW'(E_BLK))   region = REG_BLACK;
    else if (pix < PW'(E_TIM))   region = REG_TIMING;
    else if (pix < PW'(E_ACTF))  region = REG_ACTIVE;
    else if (pix < PW'(E_TIM2))  region = REG_TIMING;
    else                         region = REG_BLACK;
  end
endmodule

// File: rtl/hseq_ccd_sequencer.sv
module hseq_ccd_sequencer
  import hseq_pkg::*;
#(
  parameter int N_DUMMY  = 7,
  parameter int N_BLACK  = 20,
  parameter int N_TIMING = 4,
  parameter int N_ACTIVE = 1024,
  parameter int LINE_PIX = 1184,
  localparam int PW = $clog2(LINE_PIX),
  localparam int NPH = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           line_start,
  input  logic           split_mode,
  output logic           xfer,
  output logic [NPH-1:0] ph_l,
  output logic [NPH-1:0] ph_r,
  output logic           sg_l,
  output logic           sg_r,
  output logic           rg_l,
  output logic           rg_r,
  output logic           rgn_dummy,
  output logic           rgn_black,
  output logic           rgn_timing,
  output logic           rgn_active
);
  localparam logic [NPH-1:0] PH_IDLE = NPH'(1);
  localparam int SG_FIRST = SLOTS / 2;

  logic              busy, split_q, in_xfer;
  logic [SLOT_W-1:0] slot;
  logic [PW-1:0]     pix;
  logic [NPH-1:0]    ph_fwd, ph_rev;
  region_e           region;

  hseq_slot_timer #(.LINE_PIX(LINE_PIX)) u_timer (
    .clk(clk), .rst(rst), .line_start(line_start), .split_req(split_mode),
    .busy(busy), .slot(slot), .pix(pix), .split_q(split_q)
  );

  hseq_phase_gen #(.NPH(NPH)) u_phase (.slot(slot), .ph(ph_fwd));

  hseq_region_tag #(
    .N_DUMMY(N_DUMMY), .N_BLACK(N_BLACK), .N_TIMING(N_TIMING),
    .N_ACTIVE(N_ACTIVE), .PW(PW)
  ) u_region (.pix(pix), .split(split_q), .region(region), .in_xfer(in_xfer));

  // right half in split mode shifts the other way: reversed phase order
  for (genvar k = 0; k < NPH; k++) begin : g_rev
    assign ph_rev[k] = ph_fwd[NPH-1-k];
  end

  always_ff @(posedge clk) begin
    if (rst || !(busy && in_xfer)) begin
      xfer       <= 1'b0;
      ph_l       <= PH_IDLE;
      ph_r       <= PH_IDLE;
      sg_l       <= 1'b0;
      sg_r       <= 1'b0;
      rg_l       <= 1'b0;
      rg_r       <= 1'b0;
      rgn_dummy  <= 1'b0;
      rgn_black  <= 1'b0;
      rgn_timing <= 1'b0;
      rgn_active <= 1'b0;
    end else begin
      xfer       <= 1'b1;
      ph_l       <= ph_fwd;
      ph_r       <= split_q ? ph_rev : ph_fwd;
      sg_l       <= (int'(slot) >= SG_FIRST);
      sg_r       <= split_q && (int'(slot) >= SG_FIRST);
      rg_l       <= (slot == '0);
      rg_r       <= split_q && (slot == '0);
      rgn_dummy  <= (region == REG_DUMMY);
      rgn_black  <= (region == REG_BLACK);
      rgn_timing <= (region == REG_TIMING);
      rgn_active <= (region == REG_ACTIVE);
    end
  end

  assert_phase_count_R3: assert property (@(posedge clk) disable iff (rst)
    xfer |-> ($countones(ph_l) >= 1 && $countones(ph_l) <= 2));
  assert_rg_in_xfer_R4: assert property (@(posedge clk) disable iff (rst)
    (rg_l || rg_r) |-> xfer);
  assert_single_right_R5: assert property (@(posedge clk) disable iff (rst)
    (xfer && !split_q) |-> (ph_r == ph_l && !sg_r && !rg_r));
  assert_region_onehot_R8: assert property (@(posedge clk) disable iff (rst)
    xfer |-> ($countones({rgn_dummy, rgn_black, rgn_timing, rgn_active}) == 1));
  assert_idle_flags_R1: assert property (@(posedge clk) disable iff (rst)
    !xfer |-> ($onehot0(ph_l) && !sg_l && !rgn_active && !rgn_dummy));
endmodule

// File: tb/tb_hseq_ccd_sequencer.sv
`timescale 1ns/1ps
module tb_hseq_ccd_sequencer;
  localparam int ND = 7, NB = 20, NT = 4, NA = 1024, LP = 1184;
  localparam int LINE_CLK = 6 * LP;
  localparam int LEN_SINGLE = ND + NB + NT + NA + NT + NB;
  localparam int LEN_SPLIT  = ND + NB + NT + NA / 2;

  logic clk = 1'b0, rst = 1'b1, line_start = 1'b0, split_mode = 1'b0;
  logic xfer, sg_l, sg_r, rg_l, rg_r, rgn_dummy, rgn_black, rgn_timing, rgn_active;
  logic [2:0] ph_l, ph_r;

  int total = 0, bad = 0;
  int age = -1;
  bit msplit = 1'b0;
  bit done = 1'b0;
  string scen = "R1 reset";

  always #4 clk = ~clk;

  hseq_ccd_sequencer dut (
    .clk(clk), .rst(rst), .line_start(line_start), .split_mode(split_mode),
    .xfer(xfer), .ph_l(ph_l), .ph_r(ph_r), .sg_l(sg_l), .sg_r(sg_r),
    .rg_l(rg_l), .rg_r(rg_r), .rgn_dummy(rgn_dummy), .rgn_black(rgn_black),
    .rgn_timing(rgn_timing), .rgn_active(rgn_active)
  );

  function automatic bit mbusy();
    return age >= 0 && age < LINE_CLK;
  endfunction

  // expected region flags {active,timing,black,dummy} for pixel p
  function automatic logic [3:0] exp_region(int p, bit sp);
    if (p < ND) return 4'b0001;
    if (p < ND + NB) return 4'b0010;
    if (p < ND + NB + NT) return 4'b0100;
    if (p < ND + NB + NT + (sp ? NA / 2 : NA)) return 4'b1000;
    if (p < ND + NB + 2 * NT + NA) return 4'b0100;
    return 4'b0010;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s [%s] t=%0t actual=%0h expected=%0h", tag, scen, $time, act, exp);
    end
  endtask

  task automatic check_outputs();
    bit on;
    int n, p, s;
    logic [2:0] el, er;
    logic [3:0] ef, af;
    bit erg, esg, ergr, esgr;
    on = 1'b0; p = 0; s = 0;
    if (age >= 1 && age <= LINE_CLK) begin
      n = age - 1; p = n / 6; s = n % 6;
      on = p < (msplit ? LEN_SPLIT : LEN_SINGLE);
    end
    af = {rgn_active, rgn_timing, rgn_black, rgn_dummy};
    if (!on) begin
      chk(xfer == 1'b0 && ph_l == 3'b001 && ph_r == 3'b001, "R1", {xfer, ph_l, ph_r}, 7'b0001001);
      chk({sg_l, sg_r, rg_l, rg_r} == 4'b0 && af == 4'b0, "R1", {sg_l, sg_r, rg_l, rg_r, af}, 0);
      return;
    end
    el = {(s >= 4 || s == 0), (s >= 2 && s <= 4), (s <= 2)};
    er = msplit ? {el[0], el[1], el[2]} : el;
    erg = (s == 0); esg = (s >= 3);
    ergr = msplit && erg; esgr = msplit && esg;
    ef = exp_region(p, msplit);
    chk(xfer == 1'b1, "R7", xfer, 1);
    chk(ph_l == el, "R3", ph_l, el);
    chk(ph_r == er && sg_r == esgr && rg_r == ergr, msplit ? "R6" : "R5",
        {ph_r, sg_r, rg_r}, {er, esgr, ergr});
    chk(sg_l == esg && rg_l == erg, "R4", {sg_l, rg_l}, {esg, erg});
    chk(af == ef, msplit ? "R9" : "R8", af, ef);
  endtask

  // one clock: drive at negedge, update model at posedge, check at next negedge
  task automatic step(bit ls, bit sp);
    line_start = ls;
    split_mode = sp;
    @(posedge clk);
    if (rst) age = -1;
    else if (!mbusy() && ls) begin age = 0; msplit = sp; end
    else if (age >= 0 && age <= LINE_CLK + 1) age++;
    @(negedge clk);
    check_outputs();
  endtask

  task automatic drain(int noise_pct, bit toggle, bit sp);
    while (mbusy()) begin
      step(($urandom % 100) < noise_pct, toggle ? 1'($urandom) : sp);
    end
    repeat (3) step(1'b0, sp);
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd1357);
    @(negedge clk);
    // R1: reset state
    repeat (4) step(1'b1, 1'b1);
    rst = 1'b0;
    scen = "R1 idle";
    repeat (5) step(1'b0, 1'b0);

    // R2 R8: single-output line, clean strobe
    scen = "R2 single";
    step(1'b1, 1'b0);
    drain(0, 1'b0, 1'b0);

    // R9 R10 R11: split line with mode toggling and stray strobes
    scen = "R10 R11 split noisy";
    step(1'b1, 1'b1);
    drain(3, 1'b1, 1'b0);

    // R11: strobe held high across the line end restarts at the first idle edge
    scen = "R11 held strobe";
    step(1'b1, 1'b0);
    repeat (LINE_CLK + 2) step(1'b1, 1'b1);
    drain(0, 1'b0, 1'b0);

    // random lines
    for (int i = 0; i < 3; i++) begin
      bit sp;
      sp = 1'($urandom);
      scen = "R7 random";
      repeat ($urandom % 20) step(1'b0, 1'($urandom));
      step(1'b1, sp);
      drain(2, 1'b1, sp);
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired, actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule